// File: doc/BRIEF.md
# Lane-Partitioned SIMD Integer Adder

This block adds or subtracts two packed integer vectors in one pass, treating the operand words as a row of independent lanes. One input picks the lane width: 8, 16, 32 or 64 bits. Another input picks whether the whole 128-bit vector is active or only its lower 64 bits. The number of lanes is the active width divided by the lane width. A carry or borrow never crosses from one lane into the next.

Each lane handles its element as signed or unsigned, as a type input selects. A two-bit modifier then picks the form of the result:
- plain modular wrap;
- saturation to the element's range;
- the halved full-precision sum or difference;
- the halved value rounded up at the half point.

A request is issued with a valid/ready pair. The packed result, a valid pulse and a flag that tells whether any lane was clamped are all registered one clock after the request is accepted.

Top module: `simd_lane_adder`

## Requirements
- R1: `lane_sz` selects the lane width: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. Lane k occupies bits [k*W+W-1 : k*W]. No carry or borrow passes between lanes.
- R2: With `wide`=1 all 128 bits are processed. With `wide`=0 only bits 63:0 are processed, and result bits 127:64 are zero whatever the operands hold.
- R3: With `mode`=0 (wrap), each lane returns (a+b) or (a-b) modulo 2^W, and `is_signed` has no effect on it.
- R4: With `mode`=1 (saturate) and `is_signed`=0, a lane whose exact result exceeds 2^W-1 returns all ones, and one whose exact result is below 0 returns 0.
- R5: With `mode`=1 and `is_signed`=1, a lane whose exact result exceeds 2^(W-1)-1 returns that maximum, and one below -2^(W-1) returns -2^(W-1).
- R6: With `mode`=2 (halve), each lane returns floor((a±b)/2). The sum or difference is formed at full precision, using the element's signedness, before the shift.
- R7: With `mode`=3 (rounding halve), each lane returns floor((a±b+1)/2), also at full precision.
- R8: `res_sat` is 1 exactly when `mode`=1 and at least one active lane was clamped. In every other mode it is 0.
- R9: `res_valid` pulses high in the cycle after each accepted request (`req_valid` and `req_ready`). With no accepted request it is low, and `res_data` holds its value.
- R10: During reset `res_valid`, `res_sat` and `res_data` are 0 and `req_ready` is low. Outside reset `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| wide | input | 1 | 1: full 128-bit vector, 0: lower 64 bits only |
| lane_sz | input | 2 | Lane width code (0:8, 1:16, 2:32, 3:64) |
| is_signed | input | 1 | Element type: 1 signed, 0 unsigned |
| is_sub | input | 1 | 1: a-b, 0: a+b |
| mode | input | 2 | 0 wrap, 1 saturate, 2 halve, 3 rounding halve |
| opa | input | 128 | Operand vector a |
| opb | input | 128 | Operand vector b |
| res_valid | output | 1 | Result valid pulse |
| res_data | output | 128 | Packed lane results |
| res_sat | output | 1 | Some active lane was clamped |

## Verification
Operands made of all ones plus one show whether carries are cut at the chosen lane boundaries. A carry that leaks gives nonzero lanes where every lane should wrap to zero. Vectors filled with the signed maximum, the signed minimum or zero, each driven at every lane width, separate the signed clamp bounds from the unsigned ones and show which lanes set the clamp flag. Pseudo-random vectors in the halving and rounding-halving modes expose a sum formed too narrow or a rounding bit that is lost. Narrow-mode vectors with nonzero upper halves show whether those bits leak into the result.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam logic [1:0] MODE_WRAP  = 2'd0;
  localparam logic [1:0] MODE_SAT   = 2'd1;
  localparam logic [1:0] MODE_HALF  = 2'd2;
  localparam logic [1:0] MODE_RHALF = 2'd3;
  localparam int NUM_SIZES = 4;
  localparam int BASE_LANE_W = 8;
endpackage

// File: rtl/simd_lane_unit.sv
module simd_lane_unit
  import simd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sgn,
  input  logic         sub,
  input  logic [1:0]   mode,
  output logic [W-1:0] y,
  output logic         clamp
);
  localparam int XW = W + 2;

  logic [XW-1:0] ea, eb, full, rnd, shr;
  logic          ovf_s;

  always_comb begin
    ea = sgn ? {{2{a[W-1]}}, a} : {2'b00, a};
    eb = sgn ? {{2{b[W-1]}}, b} : {2'b00, b};
    full = sub ? (ea - eb) : (ea + eb);
    rnd = full + XW'(mode == MODE_RHALF);
    shr = XW'($signed(rnd) >>> 1);
    ovf_s = (full[XW-1] != full[W-1]) || (full[W] != full[W-1]);
    clamp = 1'b0;
    y = W'(full);
    case (mode)
      MODE_SAT: begin
        if (sgn) begin
          if (ovf_s) begin
            clamp = 1'b1;
            y = full[XW-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
          end
        end else if (full[XW-1]) begin
          clamp = 1'b1;
          y = '0;
        end else if (full[W]) begin
          clamp = 1'b1;
          y = '1;
        end
      end
      MODE_HALF, MODE_RHALF: y = W'(shr);
      default: y = W'(full);
    endcase
  end
endmodule

// File: rtl/simd_lane_bank.sv
module simd_lane_bank
  import simd_pkg::*;
#(
  parameter int VEC_W = 128,
  parameter int LW    = 8
) (
  input  logic [VEC_W-1:0] a,
  input  logic [VEC_W-1:0] b,
  input  logic             wide,
  input  logic             sgn,
  input  logic             sub,
  input  logic [1:0]       mode,
  output logic [VEC_W-1:0] y,
  output logic             clamp_any
);
  localparam int NL      = VEC_W / LW;
  localparam int NL_HALF = (NL / 2 > 0) ? NL / 2 : 1;

  logic [NL-1:0] clamp_v;
  logic [NL-1:0] act_mask;

  for (genvar i = 0; i < NL; i++) begin : g_lane
    simd_lane_unit #(.W(LW)) u_lane (
      .a    (a[i*LW +: LW]),
      .b    (b[i*LW +: LW]),
      .sgn  (sgn),
      .sub  (sub),
      .mode (mode),
      .y    (y[i*LW +: LW]),
      .clamp(clamp_v[i])
    );
    assign act_mask[i] = wide || (i < NL_HALF);
  end

  assign clamp_any = |(clamp_v & act_mask);
endmodule

// File: rtl/simd_lane_adder.sv
module simd_lane_adder
  import simd_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             wide,
  input  logic [1:0]       lane_sz,
  input  logic             is_signed,
  input  logic             is_sub,
  input  logic [1:0]       mode,
  input  logic [VEC_W-1:0] opa,
  input  logic [VEC_W-1:0] opb,
  output logic             res_valid,
  output logic [VEC_W-1:0] res_data,
  output logic             res_sat
);
  localparam int HALF_W = VEC_W / 2;

  logic [VEC_W-1:0] a_m, b_m, hi_mask;
  logic [VEC_W-1:0] bank_y [NUM_SIZES];
  logic [NUM_SIZES-1:0] bank_clamp;
  logic [VEC_W-1:0] sel_y;
  logic             sel_clamp;
  logic             accept;

  assign hi_mask = wide ? '1 : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
  assign a_m     = opa & hi_mask;
  assign b_m     = opb & hi_mask;

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    simd_lane_bank #(.VEC_W(VEC_W), .LW(BASE_LANE_W << s)) u_bank (
      .a        (a_m),
      .b        (b_m),
      .wide     (wide),
      .sgn      (is_signed),
      .sub      (is_sub),
      .mode     (mode),
      .y        (bank_y[s]),
      .clamp_any(bank_clamp[s])
    );
  end

  always_comb begin
    sel_y     = bank_y[lane_sz] & hi_mask;
    sel_clamp = bank_clamp[lane_sz];
  end

  assign req_ready = !rst;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      res_sat   <= 1'b0;
    end else begin
      res_valid <= accept;
      if (accept) begin
        res_data <= sel_y;
        res_sat  <= sel_clamp;
      end
    end
  end
endmodule

// File: rtl/simd_lane_adder_chk.sv
module simd_lane_adder_chk #(
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             wide,
  input logic             is_sub,
  input logic [1:0]       mode,
  input logic [VEC_W-1:0] opa,
  input logic [VEC_W-1:0] opb,
  input logic             res_valid,
  input logic [VEC_W-1:0] res_data,
  input logic             res_sat
);
  localparam int HALF_W = VEC_W / 2;

  AST_VALID_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> res_valid); // R9
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready) |=> !res_valid); // R9
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready) |=> $stable(res_data)); // R9
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !wide) |=> (res_data[VEC_W-1:HALF_W] == '0)); // R2
  AST_SAT_FLAG_MODE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && mode != 2'd1) |=> !res_sat); // R8
  AST_LOW_BYTE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && mode == 2'd0 && !is_sub) |=>
      (res_data[7:0] == 8'($past(opa[7:0]) + $past(opb[7:0])))); // R3
  AST_READY_OUT_OF_RESET: assert property (@(posedge clk)
    !rst |-> req_ready); // R10
endmodule

bind simd_lane_adder simd_lane_adder_chk #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .wide(wide), .is_sub(is_sub), .mode(mode), .opa(opa), .opb(opb),
  .res_valid(res_valid), .res_data(res_data), .res_sat(res_sat)
);

// File: tb/tb_simd_lane_adder.sv
module tb_simd_lane_adder;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic         wide = 1'b1;
  logic [1:0]   lane_sz = 2'd0;
  logic         is_signed = 1'b0;
  logic         is_sub = 1'b0;
  logic [1:0]   mode = 2'd0;
  logic [127:0] opa = '0;
  logic [127:0] opb = '0;
  logic         res_valid;
  logic [127:0] res_data;
  logic         res_sat;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [63:0] seed = 64'h9E3779B97F4A7C15;

  always #10 clk = ~clk;

  simd_lane_adder dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .wide(wide), .lane_sz(lane_sz), .is_signed(is_signed), .is_sub(is_sub),
    .mode(mode), .opa(opa), .opb(opb), .res_valid(res_valid),
    .res_data(res_data), .res_sat(res_sat)
  );

  function automatic logic [64:0] ref_lane(input logic [63:0] a, input logic [63:0] b,
      input int w, input logic sg, input logic sb, input logic [1:0] md);
    logic signed [67:0] one, m, ea, eb, f, hi, lo, r;
    logic c;
    one = 68'sd1;
    m  = (one <<< w) - one;
    ea = $signed({4'b0, a}) & m;
    eb = $signed({4'b0, b}) & m;
    if (sg && a[w-1]) ea = ea - (one <<< w);
    if (sg && b[w-1]) eb = eb - (one <<< w);
    f = sb ? ea - eb : ea + eb;
    c = 1'b0;
    r = f;
    case (md)
      2'd1: begin
        if (sg) begin
          hi = (one <<< (w-1)) - one;
          lo = -(one <<< (w-1));
        end else begin
          hi = m;
          lo = 68'sd0;
        end
        if (f > hi) begin r = hi; c = 1'b1; end
        else if (f < lo) begin r = lo; c = 1'b1; end
      end
      2'd2: r = f >>> 1;
      2'd3: r = (f + one) >>> 1;
      default: r = f;
    endcase
    return {c, 64'(r & m)};
  endfunction

  function automatic logic [127:0] rep(input logic [1:0] lsz, input logic [63:0] v);
    logic [127:0] o;
    int w;
    w = 8 << lsz;
    o = '0;
    for (int i = 0; i < 128 / w; i++)
      o = o | (({64'b0, v} & ((128'd1 << w) - 128'd1)) << (i * w));
    return o;
  endfunction

  function automatic logic [63:0] nxt(input logic [63:0] s);
    logic [63:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 7);
    x = x ^ (x << 17);
    return x;
  endfunction

  task automatic rnd128(output logic [127:0] v);
    seed = nxt(seed);
    v[63:0] = seed;
    seed = nxt(seed);
    v[127:64] = seed;
  endtask

  task automatic check(input string tag, input string what, input logic [127:0] act,
      input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic issue(input string tag, input logic w, input logic [1:0] lsz,
      input logic sg, input logic sb, input logic [1:0] md,
      input logic [127:0] a, input logic [127:0] b);
    logic [127:0] exp;
    logic esat;
    logic [64:0] r;
    int lw, n;
    lw = 8 << lsz;
    n = (w ? 128 : 64) / lw;
    exp = '0;
    esat = 1'b0;
    for (int i = 0; i < n; i++) begin
      r = ref_lane(64'(a >> (i * lw)), 64'(b >> (i * lw)), lw, sg, sb, md);
      exp = exp | ({64'b0, r[63:0]} << (i * lw));
      esat = esat | r[64];
    end
    @(negedge clk);
    req_valid = 1'b1; wide = w; lane_sz = lsz; is_signed = sg; is_sub = sb;
    mode = md; opa = a; opb = b;
    @(negedge clk);
    req_valid = 1'b0;
    check(tag, "res_valid", {127'b0, res_valid}, 128'd1);
    check(tag, "res_data", res_data, exp);
    check(tag, "res_sat", {127'b0, res_sat}, {127'b0, esat});
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R10", "res_valid in reset", {127'b0, res_valid}, '0);
    check("R10", "res_data in reset", res_data, '0);
    check("R10", "res_sat in reset", {127'b0, res_sat}, '0);
    check("R10", "ready in reset", {127'b0, req_ready}, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R10", "ready after reset", {127'b0, req_ready}, 128'd1);
  endtask

  // R1 carry isolation and R3 modular wrap, all lane widths
  task automatic t_wrap();
    logic [127:0] a, b;
    for (int s = 0; s < 4; s++) begin
      issue("R1", 1'b1, 2'(s), 1'b0, 1'b0, 2'd0, '1, rep(2'(s), 64'd1));
      issue("R1", 1'b1, 2'(s), 1'b0, 1'b1, 2'd0, '0, rep(2'(s), 64'd1));
      for (int k = 0; k < 3; k++) begin
        rnd128(a); rnd128(b);
        issue("R3", 1'b1, 2'(s), k[0], k[1], 2'd0, a, b);
      end
    end
  endtask

  // R4 unsigned clamp, R8 flag
  task automatic t_usat();
    logic [127:0] a, b;
    for (int s = 0; s < 4; s++) begin
      issue("R4", 1'b1, 2'(s), 1'b0, 1'b0, 2'd1, '1, rep(2'(s), 64'd1));
      issue("R4", 1'b1, 2'(s), 1'b0, 1'b1, 2'd1, '0, rep(2'(s), 64'd1));
      rnd128(a); rnd128(b);
      issue("R4", 1'b1, 2'(s), 1'b0, s[0], 2'd1, a, b);
    end
  endtask

  // R5 signed clamp to max and min
  task automatic t_ssat();
    logic [63:0] mx, mn;
    logic [127:0] a, b;
    for (int s = 0; s < 4; s++) begin
      mx = 64'hFFFF_FFFF_FFFF_FFFF >> (64 - (8 << s) + 1);
      mn = 64'd1 << ((8 << s) - 1);
      issue("R5", 1'b1, 2'(s), 1'b1, 1'b0, 2'd1, rep(2'(s), mx), rep(2'(s), 64'd1));
      issue("R5", 1'b1, 2'(s), 1'b1, 1'b1, 2'd1, rep(2'(s), mn), rep(2'(s), 64'd1));
      issue("R5", 1'b1, 2'(s), 1'b1, 1'b0, 2'd1, rep(2'(s), mn), rep(2'(s), mn));
      rnd128(a); rnd128(b);
      issue("R5", 1'b1, 2'(s), 1'b1, s[1], 2'd1, a, b);
    end
  endtask

  // R6 truncating halve and R7 rounding halve, extremes and random
  task automatic t_halve();
    logic [127:0] a, b;
    for (int s = 0; s < 4; s++) begin
      issue("R6", 1'b1, 2'(s), 1'b0, 1'b0, 2'd2, '1, '1);
      issue("R6", 1'b1, 2'(s), 1'b1, 1'b1, 2'd2, '0, rep(2'(s), 64'd1));
      issue("R7", 1'b1, 2'(s), 1'b0, 1'b0, 2'd3, '1, rep(2'(s), 64'd2));
      issue("R7", 1'b1, 2'(s), 1'b1, 1'b0, 2'd3, '1, '0);
      for (int k = 0; k < 2; k++) begin
        rnd128(a); rnd128(b);
        issue("R6", 1'b1, 2'(s), k[0], s[0], 2'd2, a, b);
        rnd128(a); rnd128(b);
        issue("R7", 1'b1, 2'(s), k[0], s[1], 2'd3, a, b);
      end
    end
  endtask

  // R2 narrow width zeroes upper half
  task automatic t_narrow();
    logic [127:0] a, b;
    for (int s = 0; s < 4; s++) begin
      for (int md = 0; md < 4; md++) begin
        rnd128(a); rnd128(b);
        issue("R2", 1'b0, 2'(s), s[0], md[0], 2'(md), a, b);
      end
    end
  endtask

  // R8 flag low without clamping or outside saturate mode
  task automatic t_flag();
    issue("R8", 1'b1, 2'd0, 1'b0, 1'b0, 2'd1, rep(2'd0, 64'd3), rep(2'd0, 64'd4));
    issue("R8", 1'b1, 2'd1, 1'b0, 1'b0, 2'd0, '1, '1);
    issue("R8", 1'b1, 2'd2, 1'b1, 1'b1, 2'd2, rep(2'd2, 64'h8000_0000), rep(2'd2, 64'd1));
  endtask

  // R9 hold and no valid without a request
  task automatic t_hold();
    logic [127:0] a, b, snap;
    rnd128(a); rnd128(b);
    issue("R9", 1'b1, 2'd1, 1'b0, 1'b0, 2'd0, a, b);
    snap = res_data;
    @(negedge clk);
    opa = ~opa; opb = ~opb;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R9", "idle res_valid", {127'b0, res_valid}, '0);
      check("R9", "idle res_data hold", res_data, snap);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_wrap();
    t_usat();
    t_ssat();
    t_halve();
    t_narrow();
    t_flag();
    t_hold();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule